// File: doc/BRIEF.md
# Packet Payload Statistics Monitor

This block watches a 64-bit AXI4-Stream link that carries headered packets, and it does so passively. It only reads the valid, ready, last and data signals and never drives any of them. In each packet the first word is a header. When the header's time flag is set, the word that follows it is a timestamp. Every word after those two is payload. The monitor folds each payload word into five running values: a word count, a wrapping sum, a minimum, a maximum and an XOR check value.

When the final word of a packet is transferred, the block latches the five values together with the decoded header fields and the timestamp. It then raises a one-cycle done strobe. The latched results stay on the outputs until the next packet ends, so a scoreboard or a debug capture can collect per-packet figures at its own pace. Parameters set the count width and the initial value of the minimum, and they select an unsigned or a signed compare for minimum and maximum. With the default parameters the compare is unsigned.

Top module: `pkt_stat_probe`

## Requirements
- R1: A word is taken only in a cycle where s_tvalid and s_tready are both 1. Words seen in any other cycle, including any with s_tlast set, change no state and raise no done strobe.
- R2: The first transferred word of a packet is its header. Its fields are reported as follows: rep_kind from bits 63:62, rep_has_ts from bit 61, rep_eob from bit 60, rep_seq from bits 59:48, rep_len from bits 47:32, rep_src from bits 31:16 and rep_dst from bits 15:0.
- R3: If header bit 61 is 1, the second transferred word is the timestamp and is reported on rep_ts. If bit 61 is 0, rep_ts reports zero. Neither the header word nor the timestamp word enters the statistics.
- R4: Each payload word adds one to the 32-bit rep_cnt and adds to the 64-bit rep_sum. The sum wraps modulo 2^64.
- R5: rep_min and rep_max follow an unsigned compare. Each packet starts them at 0x7FFF_FFFF_FFFF_FFFF and 0 respectively, so a packet whose payload words all exceed 0x7FFF_FFFF_FFFF_FFFF reports that start value as its minimum.
- R6: rep_chk is the bitwise XOR of all payload words of the packet, starting from zero.
- R7: A payload word that carries s_tlast is included in the statistics.
- R8: A packet that ends on its header word, or on its timestamp word, reports its header, and its timestamp where present, with zero statistics: count 0, sum 0, minimum 0x7FFF_FFFF_FFFF_FFFF, maximum 0 and check 0.
- R9: done is 1 in exactly the one cycle that follows a transfer with s_tlast set. All rep_* outputs hold their values from that moment until the next such transfer.
- R10: After reset done is 0 and every rep_* output is 0. The first transfer after reset, and the first transfer after any s_tlast transfer, is treated as a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_tvalid | input | 1 | Observed stream valid |
| s_tready | input | 1 | Observed stream ready |
| s_tdata | input | 64 | Observed stream data |
| s_tlast | input | 1 | Observed end of packet |
| done | output | 1 | One-cycle strobe after a packet ends |
| rep_kind | output | 2 | Header packet kind field |
| rep_has_ts | output | 1 | Header time flag |
| rep_eob | output | 1 | Header end-of-burst flag |
| rep_seq | output | 12 | Header sequence number |
| rep_len | output | 16 | Header length field |
| rep_src | output | 16 | Header source id |
| rep_dst | output | 16 | Header destination id |
| rep_ts | output | 64 | Timestamp word, or zero |
| rep_cnt | output | 32 | Payload word count |
| rep_sum | output | 64 | Wrapping payload sum |
| rep_min | output | 64 | Smallest payload word |
| rep_max | output | 64 | Largest payload word |
| rep_chk | output | 64 | XOR of payload words |

## Verification
The bench ends packets on the header word and on the timestamp word. A design that counted those words as payload would report a nonzero count or fold the timestamp into the sum and check value. It holds valid high with ready low, and raises valid and last while ready is low, so a monitor that ignores ready shows spurious words or an early done. Payload words above 0x7FFF_FFFF_FFFF_FFFF check the fixed minimum start value, and a pair of all-ones words checks that the sum wraps. Back-to-back random packets, with and without timestamps, would expose a role tracker that fails to return to the header state or an accumulator that does not clear between packets.

// File: rtl/pstat_pkg.sv
package pstat_pkg;

   typedef enum logic [1:0] {
      ROLE_HDR = 2'd0,
      ROLE_TS  = 2'd1,
      ROLE_PAY = 2'd2
   } role_t;

   // Header word layout, most significant field first (bit 63 down to 0).
   typedef struct packed {
      logic [1:0]  kind;
      logic        has_ts;
      logic        eob;
      logic [11:0] seq;
      logic [15:0] len;
      logic [15:0] src;
      logic [15:0] dst;
   } hdr_t;

   localparam int unsigned HDR_BITS = $bits(hdr_t);

endpackage

// File: rtl/pstat_role.sv
module pstat_role
   import pstat_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   input  logic  beat,
   input  logic  last,
   input  logic  ts_flag,
   output role_t role
);

   role_t role_q;
   role_t role_d;

   always_comb begin
      role_d = role_q;
      if (beat) begin
         if (last) begin
            role_d = ROLE_HDR;
         end else begin
            unique case (role_q)
               ROLE_HDR: role_d = ts_flag ? ROLE_TS : ROLE_PAY;
               ROLE_TS:  role_d = ROLE_PAY;
               default:  role_d = ROLE_PAY;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) role_q <= ROLE_HDR;
      else     role_q <= role_d;
   end

   assign role = role_q;

endmodule

// File: rtl/pstat_accum.sv
module pstat_accum #(
   parameter int unsigned DATA_W     = 64,
   parameter int unsigned CNT_W      = 32,
   parameter logic [DATA_W-1:0] MIN_INIT = {1'b0, {(DATA_W-1){1'b1}}},
   parameter bit          SIGNED_CMP = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              beat,
   input  logic              is_pay,
   input  logic              last,
   input  logic [DATA_W-1:0] word,
   output logic [CNT_W-1:0]  nx_cnt,
   output logic [DATA_W-1:0] nx_sum,
   output logic [DATA_W-1:0] nx_min,
   output logic [DATA_W-1:0] nx_max,
   output logic [DATA_W-1:0] nx_chk
);

   logic [CNT_W-1:0]  acc_cnt;
   logic [DATA_W-1:0] acc_sum, acc_min, acc_max, acc_chk;
   logic              below_min, above_max;
   logic              take;

   generate
      if (SIGNED_CMP) begin : g_cmp_signed
         assign below_min = $signed(word) < $signed(acc_min);
         assign above_max = $signed(word) > $signed(acc_max);
      end else begin : g_cmp_unsigned
         assign below_min = word < acc_min;
         assign above_max = word > acc_max;
      end
   endgenerate

   assign take = beat && is_pay;

   always_comb begin
      nx_cnt = acc_cnt;
      nx_sum = acc_sum;
      nx_min = acc_min;
      nx_max = acc_max;
      nx_chk = acc_chk;
      if (take) begin
         nx_cnt = acc_cnt + CNT_W'(1);
         nx_sum = acc_sum + word;
         nx_chk = acc_chk ^ word;
         if (below_min) nx_min = word;
         if (above_max) nx_max = word;
      end
   end

   always_ff @(posedge clk) begin
      if (rst || (beat && last)) begin
         acc_cnt <= '0;
         acc_sum <= '0;
         acc_min <= MIN_INIT;
         acc_max <= '0;
         acc_chk <= '0;
      end else begin
         acc_cnt <= nx_cnt;
         acc_sum <= nx_sum;
         acc_min <= nx_min;
         acc_max <= nx_max;
         acc_chk <= nx_chk;
      end
   end

endmodule

// File: rtl/pkt_stat_probe.sv
module pkt_stat_probe
   import pstat_pkg::*;
#(
   parameter int unsigned DATA_W     = 64,
   parameter int unsigned CNT_W      = 32,
   parameter logic [DATA_W-1:0] MIN_INIT = {1'b0, {(DATA_W-1){1'b1}}},
   parameter bit          SIGNED_CMP = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              s_tvalid,
   input  logic              s_tready,
   input  logic [DATA_W-1:0] s_tdata,
   input  logic              s_tlast,
   output logic              done,
   output logic [1:0]        rep_kind,
   output logic              rep_has_ts,
   output logic              rep_eob,
   output logic [11:0]       rep_seq,
   output logic [15:0]       rep_len,
   output logic [15:0]       rep_src,
   output logic [15:0]       rep_dst,
   output logic [DATA_W-1:0] rep_ts,
   output logic [CNT_W-1:0]  rep_cnt,
   output logic [DATA_W-1:0] rep_sum,
   output logic [DATA_W-1:0] rep_min,
   output logic [DATA_W-1:0] rep_max,
   output logic [DATA_W-1:0] rep_chk
);

   generate
      if (DATA_W != HDR_BITS) begin : g_bad_width
         $error("pkt_stat_probe: DATA_W must equal the header width");
      end
      if (CNT_W < 1 || CNT_W > 64) begin : g_bad_cnt
         $error("pkt_stat_probe: CNT_W out of range");
      end
   endgenerate

   logic  beat;
   role_t role;
   hdr_t  hdr_q, hdr_now, hdr_in;
   logic [DATA_W-1:0] ts_q, ts_now;
   logic [CNT_W-1:0]  nx_cnt;
   logic [DATA_W-1:0] nx_sum, nx_min, nx_max, nx_chk;
   hdr_t  rep_hdr;

   assign beat   = s_tvalid && s_tready;
   assign hdr_in = hdr_t'(s_tdata);

   pstat_role u_role (
      .clk     (clk),
      .rst     (rst),
      .beat    (beat),
      .last    (s_tlast),
      .ts_flag (hdr_in.has_ts),
      .role    (role)
   );

   pstat_accum #(
      .DATA_W     (DATA_W),
      .CNT_W      (CNT_W),
      .MIN_INIT   (MIN_INIT),
      .SIGNED_CMP (SIGNED_CMP)
   ) u_accum (
      .clk    (clk),
      .rst    (rst),
      .beat   (beat),
      .is_pay (role == ROLE_PAY),
      .last   (s_tlast),
      .word   (s_tdata),
      .nx_cnt (nx_cnt),
      .nx_sum (nx_sum),
      .nx_min (nx_min),
      .nx_max (nx_max),
      .nx_chk (nx_chk)
   );

   // Header and timestamp as they stand after the current word.
   always_comb begin
      hdr_now = hdr_q;
      ts_now  = ts_q;
      if (role == ROLE_HDR) begin
         hdr_now = hdr_in;
         ts_now  = '0;
      end else if (role == ROLE_TS) begin
         ts_now  = s_tdata;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         hdr_q   <= '0;
         ts_q    <= '0;
         done    <= 1'b0;
         rep_hdr <= '0;
         rep_ts  <= '0;
         rep_cnt <= '0;
         rep_sum <= '0;
         rep_min <= '0;
         rep_max <= '0;
         rep_chk <= '0;
      end else begin
         done <= beat && s_tlast;
         if (beat) begin
            hdr_q <= hdr_now;
            ts_q  <= ts_now;
         end
         if (beat && s_tlast) begin
            rep_hdr <= hdr_now;
            rep_ts  <= ts_now;
            rep_cnt <= nx_cnt;
            rep_sum <= nx_sum;
            rep_min <= nx_min;
            rep_max <= nx_max;
            rep_chk <= nx_chk;
         end
      end
   end

   assign rep_kind   = rep_hdr.kind;
   assign rep_has_ts = rep_hdr.has_ts;
   assign rep_eob    = rep_hdr.eob;
   assign rep_seq    = rep_hdr.seq;
   assign rep_len    = rep_hdr.len;
   assign rep_src    = rep_hdr.src;
   assign rep_dst    = rep_hdr.dst;

endmodule

// File: rtl/pstat_chk.sv
module pstat_chk #(
   parameter int unsigned DATA_W     = 64,
   parameter int unsigned CNT_W      = 32,
   parameter logic [DATA_W-1:0] MIN_INIT = {1'b0, {(DATA_W-1){1'b1}}},
   parameter bit          SIGNED_CMP = 1'b0
) (
   input logic              clk,
   input logic              rst,
   input logic              s_tvalid,
   input logic              s_tready,
   input logic              s_tlast,
   input logic              done,
   input logic [CNT_W-1:0]  rep_cnt,
   input logic [DATA_W-1:0] rep_sum,
   input logic [DATA_W-1:0] rep_min,
   input logic [DATA_W-1:0] rep_max,
   input logic [DATA_W-1:0] rep_chk
);

   // R1: no completed transfer with last, no strobe
   a_r1_no_spurious_done: assert property (@(posedge clk) disable iff (rst)
      !(s_tvalid && s_tready && s_tlast) |=> !done);

   // R9: strobe follows every last transfer
   a_r9_done_after_last: assert property (@(posedge clk) disable iff (rst)
      (s_tvalid && s_tready && s_tlast) |=> done);

   // R9: results hold between strobes
   a_r9_hold: assert property (@(posedge clk) disable iff (rst)
      !done |-> ($stable(rep_cnt) && $stable(rep_sum) && $stable(rep_min)
                 && $stable(rep_max) && $stable(rep_chk)));

   // R8: an empty payload reports the start values
   a_r8_empty_stats: assert property (@(posedge clk) disable iff (rst)
      (done && rep_cnt == '0) |-> (rep_sum == '0 && rep_min == MIN_INIT
                                   && rep_max == '0 && rep_chk == '0));

   generate
      if (!SIGNED_CMP) begin : g_order
         // R5: minimum never exceeds maximum once a word was folded in
         a_r5_min_le_max: assert property (@(posedge clk) disable iff (rst)
            (done && rep_cnt != '0) |-> (rep_min <= rep_max));
      end
   endgenerate

endmodule

bind pkt_stat_probe pstat_chk #(
   .DATA_W     (DATA_W),
   .CNT_W      (CNT_W),
   .MIN_INIT   (MIN_INIT),
   .SIGNED_CMP (SIGNED_CMP)
) u_pstat_chk (
   .clk      (clk),
   .rst      (rst),
   .s_tvalid (s_tvalid),
   .s_tready (s_tready),
   .s_tlast  (s_tlast),
   .done     (done),
   .rep_cnt  (rep_cnt),
   .rep_sum  (rep_sum),
   .rep_min  (rep_min),
   .rep_max  (rep_max),
   .rep_chk  (rep_chk)
);

// File: tb/test_pkt_stat_probe.sv
`timescale 1ns/1ps
module test_pkt_stat_probe;

   localparam logic [63:0] MIN0 = 64'h7FFF_FFFF_FFFF_FFFF;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2.5 clk = ~clk;

   logic        tv = 1'b0, tr = 1'b0, tl = 1'b0;
   logic [63:0] td = '0;
   logic        done, rep_has_ts, rep_eob;
   logic [1:0]  rep_kind;
   logic [11:0] rep_seq;
   logic [15:0] rep_len, rep_src, rep_dst;
   logic [63:0] rep_ts, rep_sum, rep_min, rep_max, rep_chk;
   logic [31:0] rep_cnt;

   pkt_stat_probe i_pkt_stat_probe (
      .clk(clk), .rst(rst), .s_tvalid(tv), .s_tready(tr), .s_tdata(td), .s_tlast(tl),
      .done(done), .rep_kind(rep_kind), .rep_has_ts(rep_has_ts), .rep_eob(rep_eob),
      .rep_seq(rep_seq), .rep_len(rep_len), .rep_src(rep_src), .rep_dst(rep_dst),
      .rep_ts(rep_ts), .rep_cnt(rep_cnt), .rep_sum(rep_sum), .rep_min(rep_min),
      .rep_max(rep_max), .rep_chk(rep_chk)
   );

   int n_run = 0, n_fail = 0;
   bit finished = 1'b0;
   logic [63:0] pay [0:15];

   task automatic chkv(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] f_sum(input int n);
      logic [63:0] s = '0;
      for (int i = 0; i < n; i++) s += pay[i];
      return s;
   endfunction
   function automatic logic [63:0] f_min(input int n);
      logic [63:0] m = MIN0;
      for (int i = 0; i < n; i++) if (pay[i] < m) m = pay[i];
      return m;
   endfunction
   function automatic logic [63:0] f_max(input int n);
      logic [63:0] m = '0;
      for (int i = 0; i < n; i++) if (pay[i] > m) m = pay[i];
      return m;
   endfunction
   function automatic logic [63:0] f_chk(input int n);
      logic [63:0] c = '0;
      for (int i = 0; i < n; i++) c ^= pay[i];
      return c;
   endfunction

   // One transfer, optionally preceded by a cycle that must not count.
   task automatic beat(input logic [63:0] w, input logic last, input bit stall);
      if (stall) begin
         tv = 1'($urandom % 2);
         tr = tv ? 1'b0 : 1'($urandom % 2);
         td = {$urandom, $urandom};
         tl = 1'b1;
         @(negedge clk);
         chkv("R1 stall cycle gives no done", 64'(done), 64'd0);
      end
      tv = 1'b1; tr = 1'b1; td = w; tl = last;
      @(negedge clk);
      tv = 1'b0; tr = 1'b0; tl = 1'b0; td = '0;
   endtask

   task automatic send_pkt(input logic [63:0] hdr, input logic [63:0] ts,
                           input int n, input bit stall);
      logic [31:0] held;
      bit has_ts = hdr[61];
      beat(hdr, (n == 0) && !has_ts, stall);
      if (has_ts) beat(ts, n == 0, stall);
      for (int i = 0; i < n; i++) beat(pay[i], i == n - 1, stall);
      chkv("R9 done after last", 64'(done), 64'd1);
      chkv("R2 R10 kind", 64'(rep_kind), 64'(hdr[63:62]));
      chkv("R2 has_ts", 64'(rep_has_ts), 64'(hdr[61]));
      chkv("R2 eob", 64'(rep_eob), 64'(hdr[60]));
      chkv("R2 seq", 64'(rep_seq), 64'(hdr[59:48]));
      chkv("R2 len", 64'(rep_len), 64'(hdr[47:32]));
      chkv("R2 src", 64'(rep_src), 64'(hdr[31:16]));
      chkv("R2 dst", 64'(rep_dst), 64'(hdr[15:0]));
      chkv("R3 timestamp", rep_ts, has_ts ? ts : 64'd0);
      chkv("R4 R7 R8 count", 64'(rep_cnt), 64'(n));
      chkv("R4 sum", rep_sum, f_sum(n));
      chkv("R5 min", rep_min, f_min(n));
      chkv("R5 max", rep_max, f_max(n));
      chkv("R6 check", rep_chk, f_chk(n));
      held = rep_cnt;
      @(negedge clk);
      chkv("R9 done one cycle", 64'(done), 64'd0);
      chkv("R9 results held", 64'(rep_cnt), 64'(held));
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chkv("R10 reset done", 64'(done), 64'd0);
      chkv("R10 reset count", 64'(rep_cnt), 64'd0);
      chkv("R10 reset min", rep_min, 64'd0);
      rst = 1'b0;
      @(negedge clk);

      // R8: last on the header word, with and without the time flag clear
      send_pkt(64'h9ABC_1234_5678_9DEF & ~(64'd1 << 61), 64'd0, 0, 1'b0);
      // R8: last on the timestamp word
      send_pkt(64'h6123_0040_AAAA_5555, 64'hDEAD_BEEF_0000_0001, 0, 1'b1);
      // R4: sum wraps
      pay[0] = '1; pay[1] = '1;
      send_pkt(64'h0005_0018_0001_0002, 64'd0, 2, 1'b0);
      // R5: all words above the minimum start value
      pay[0] = 64'h8000_0000_0000_0000; pay[1] = 64'hF000_0000_0000_0001;
      pay[2] = 64'h9000_0000_0000_0000;
      send_pkt(64'h2FFF_0030_0003_0004, 64'h1111_2222_3333_4444, 3, 1'b1);
      // R7: single payload word carrying last
      pay[0] = 64'h0000_0000_0000_0007;
      send_pkt(64'hC001_0010_00AA_00BB, 64'd0, 1, 1'b0);

      // Random packets, back to back
      for (int k = 0; k < 60; k++) begin
         logic [63:0] h;
         int n;
         n = int'($urandom % 10);
         h = {$urandom, $urandom};
         for (int i = 0; i < n; i++) pay[i] = {$urandom, $urandom};
         send_pkt(h, {$urandom, $urandom}, n, 1'($urandom % 2));
      end

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: run did not complete actual=hung expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule